// File: doc/BRIEF.md
# Seven-Level Switched-Capacitor Gain and Phase Controller

This block is the digital control core of a seven-level switched-capacitor boost inverter. From the system clock it builds a repeating switching cycle. Each cycle has a charge interval, a dead gap, a transfer interval and a second dead gap. It drives eight switch enables. In the charge interval the three pumping capacitors charge in parallel. In the transfer interval the capacitor stack is set to a series ratio of 3x, 2x or 1x and connected to one side of the output bridge.

At the start of every cycle the block captures a signed, digitized sinusoidal reference and an unsigned output magnitude sample. The reference magnitude is compared with thirds of full scale to pick the gain. The reference sign picks the half-wave, and so which output switch closes. A comparison of reference magnitude against output magnitude decides whether the selected boost switch fires in this cycle. When the output is already above the reference, that pulse is skipped. This skipping gives pulse-frequency regulation.

The cycle timing comes from two parameters: interval length and gap length. The defaults give 100 kHz from a 250 MHz clock. The power stage, the converters and sine generation sit outside this block.

Top module: `scinv_phase_ctrl`

## Requirements
- R1: While `rst` is sampled high, all of `swEn` is 0. At the first rising edge with `rst` low, `swEn` becomes 8'h01, which starts the charge interval.
- R2: The switching period is 2*(PHASE_CLKS+DEAD_CLKS) clocks. `swEn[0]` rises once per period, stays high for PHASE_CLKS clocks, and the transfer pattern lasts PHASE_CLKS clocks.
- R3: During the charge interval `swEn` equals 8'h01 (bit 0 is the parallel-charge switch), whatever the inputs are.
- R4: Between the two intervals `swEn` is all zero for DEAD_CLKS clocks (at least one). Bit 0 is never high in the same clock as any of bits 7..1.
- R5: The reference magnitude m is |refSample|, with full scale FS = 2^(REF_W-1). The gain is 3x when 3m >= 2FS, 2x when FS <= 3m < 2FS, and 1x when 3m < FS.
- R6: The 3x transfer pattern has bits 1 and 2 (series switches) set. Bit 5 is set when boost is enabled. Bits 3 and 4 are clear.
- R7: The 2x transfer pattern has bit 1 set. Bit 4 is set when boost is enabled. Bits 2, 3 and 5 are clear.
- R8: The 1x transfer pattern has only bit 3 set, when boost is enabled. Bits 1, 2, 4 and 5 are clear.
- R9: Boost is enabled when m >= outMag. Otherwise the selected boost bit (5, 4 or 3) is skipped for that cycle, and the other transfer bits are unchanged.
- R10: In the transfer interval exactly one polarity bit is set: bit 6 for refSample >= 0, bit 7 for refSample < 0.
- R11: refSample and outMag are captured only at the first clock of the charge interval. A change later in the cycle does not alter that cycle's transfer pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| refSample | input | REF_W | Signed sinusoidal reference sample |
| outMag | input | REF_W | Unsigned output magnitude sample |
| swEn | output | 8 | Switch enables; bit n drives switch n+1 |

## Verification
The bench drives magnitudes on both sides of each one-third threshold, for example 682 against 683 and 1365 against 1366. A design that rounds the thresholds would pick the wrong ratio there. It sets outMag equal to the reference magnitude and one above it. A design with a strict comparison would skip a pulse it should fire. It changes the reference sign after the capture point. A design that does not hold its captured inputs would flip the polarity switch in the middle of a cycle. It also tracks every clock against a cycle model, so a missing dead gap, an overlap or a wrong period shows up at once.

// File: rtl/scinv_pkg.sv
package scinv_pkg;

  typedef enum logic [1:0] {
    GAIN_1X,
    GAIN_2X,
    GAIN_3X
  } gain_e;

  typedef enum logic [1:0] {
    ST_CHARGE,
    ST_GAP_A,
    ST_XFER,
    ST_GAP_B
  } phase_e;

  // strobes from sequencer to switch datapath
  typedef struct packed {
    logic sampleNow;
    logic chargeOn;
    logic xferOn;
  } strobe_t;

  localparam int SW_CNT   = 8;
  localparam int SW_CHG   = 0;
  localparam int SW_SER_A = 1;
  localparam int SW_SER_B = 2;
  localparam int SW_BST1  = 3;
  localparam int SW_BST2  = 4;
  localparam int SW_BST3  = 5;
  localparam int SW_POS   = 6;
  localparam int SW_NEG   = 7;

endpackage

// File: rtl/scinv_phase_seq.sv
module scinv_phase_seq
  import scinv_pkg::*;
#(
  parameter int PHASE_CLKS = 1248,
  parameter int DEAD_CLKS  = 2
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t stb
);

  localparam int PH_LEN  = (PHASE_CLKS < 1) ? 1 : PHASE_CLKS;
  localparam int GAP_LEN = (DEAD_CLKS < 1) ? 1 : DEAD_CLKS;
  localparam int MAX_LEN = (PH_LEN > GAP_LEN) ? PH_LEN : GAP_LEN;
  localparam int SLOT_W  = $clog2(MAX_LEN + 1);
  localparam logic [SLOT_W-1:0] PH_LAST  = SLOT_W'(PH_LEN - 1);
  localparam logic [SLOT_W-1:0] GAP_LAST = SLOT_W'(GAP_LEN - 1);

  phase_e            state;
  phase_e            stateNext;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slotLast;

  always_comb begin
    case (state)
      ST_CHARGE: begin slotLast = PH_LAST;  stateNext = ST_GAP_A;  end
      ST_GAP_A:  begin slotLast = GAP_LAST; stateNext = ST_XFER;   end
      ST_XFER:   begin slotLast = PH_LAST;  stateNext = ST_GAP_B;  end
      default:   begin slotLast = GAP_LAST; stateNext = ST_CHARGE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CHARGE;
      slot  <= '0;
    end else if (slot == slotLast) begin
      state <= stateNext;
      slot  <= '0;
    end else begin
      slot  <= slot + 1'b1;
    end
  end

  always_comb begin
    stb.sampleNow = (state == ST_CHARGE) && (slot == '0);
    stb.chargeOn  = (state == ST_CHARGE);
    stb.xferOn    = (state == ST_XFER);
  end

endmodule

// File: rtl/scinv_switch_path.sv
module scinv_switch_path
  import scinv_pkg::*;
#(
  parameter int REF_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  strobe_t                 stb,
  input  logic signed [REF_W-1:0] refSample,
  input  logic        [REF_W-1:0] outMag,
  output logic        [SW_CNT-1:0] swEn
);

  localparam int TW = REF_W + 2;
  localparam logic [TW-1:0] TH_HI = TW'(1) << REF_W;        // 2 * full scale
  localparam logic [TW-1:0] TH_LO = TW'(1) << (REF_W - 1);  // full scale

  logic [REF_W-1:0] refMag;
  logic [TW-1:0]    refTriple;
  gain_e            gainNow;
  logic             boostNow;

  gain_e            heldGain;
  logic             heldBoost;
  logic             heldNeg;
  logic [SW_CNT-1:0] swNext;

  always_comb begin
    refMag    = refSample[REF_W-1] ? (~refSample + 1'b1) : refSample;
    refTriple = {2'b00, refMag} + {1'b0, refMag, 1'b0};
    if (refTriple >= TH_HI)      gainNow = GAIN_3X;
    else if (refTriple >= TH_LO) gainNow = GAIN_2X;
    else                         gainNow = GAIN_1X;
    boostNow  = (refMag >= outMag);
  end

  always_comb begin
    swNext = '0;
    if (stb.chargeOn) begin
      swNext[SW_CHG] = 1'b1;
    end else if (stb.xferOn) begin
      case (heldGain)
        GAIN_3X: begin
          swNext[SW_SER_A] = 1'b1;
          swNext[SW_SER_B] = 1'b1;
          swNext[SW_BST3]  = heldBoost;
        end
        GAIN_2X: begin
          swNext[SW_SER_A] = 1'b1;
          swNext[SW_BST2]  = heldBoost;
        end
        default: begin
          swNext[SW_BST1]  = heldBoost;
        end
      endcase
      swNext[SW_POS] = ~heldNeg;
      swNext[SW_NEG] = heldNeg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldGain  <= GAIN_1X;
      heldBoost <= 1'b0;
      heldNeg   <= 1'b0;
      swEn      <= '0;
    end else begin
      if (stb.sampleNow) begin
        heldGain  <= gainNow;
        heldBoost <= boostNow;
        heldNeg   <= refSample[REF_W-1];
      end
      swEn <= swNext;
    end
  end

endmodule

// File: rtl/scinv_phase_ctrl.sv
module scinv_phase_ctrl
  import scinv_pkg::*;
#(
  parameter int REF_W      = 12,
  parameter int PHASE_CLKS = 1248,
  parameter int DEAD_CLKS  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] refSample,
  input  logic        [REF_W-1:0] outMag,
  output logic        [7:0]       swEn
);

  strobe_t stb;

  scinv_phase_seq #(
    .PHASE_CLKS(PHASE_CLKS),
    .DEAD_CLKS (DEAD_CLKS)
  ) u_seq (
    .clk(clk),
    .rst(rst),
    .stb(stb)
  );

  scinv_switch_path #(
    .REF_W(REF_W)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .refSample(refSample),
    .outMag   (outMag),
    .swEn     (swEn)
  );

endmodule

// File: rtl/scinv_phase_ctrl_chk.sv
module scinv_phase_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] swEn
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> swEn == 8'h00);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(swEn[0] && (|swEn[7:1])));

  // R4
  gap_after_charge_chk: assert property (@(posedge clk) disable iff (rst)
    $past(swEn[0]) |-> swEn[7:1] == 7'h00);

  // R4
  gap_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    $past(|swEn[7:1]) |-> !swEn[0]);

  // R6
  ratio3_chk: assert property (@(posedge clk) disable iff (rst)
    swEn[5] |-> (swEn[1] && swEn[2] && !swEn[3] && !swEn[4]));

  // R7
  ratio2_chk: assert property (@(posedge clk) disable iff (rst)
    swEn[4] |-> (swEn[1] && !swEn[2] && !swEn[3]));

  // R8
  ratio1_chk: assert property (@(posedge clk) disable iff (rst)
    swEn[3] |-> (!swEn[1] && !swEn[2]));

  // R9
  one_boost_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(swEn[5:3]));

  // R10
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    (|swEn[5:1]) |-> $countones(swEn[7:6]) == 1);

  // R11
  hold_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(|swEn[7:6]) && (|swEn[7:6])) |-> $stable(swEn));

endmodule

bind scinv_phase_ctrl scinv_phase_ctrl_chk u_chk (
  .clk (clk),
  .rst (rst),
  .swEn(swEn)
);

// File: tb/scinv_phase_ctrl_bench.sv
module scinv_phase_ctrl_bench;

  localparam int REF_W = 12;
  localparam int PH    = 4;
  localparam int DD    = 1;
  localparam int CYC   = 2 * (PH + DD);
  localparam int FS    = 1 << (REF_W - 1);

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic signed [REF_W-1:0] refSample = '0;
  logic        [REF_W-1:0] outMag = '0;
  logic        [7:0]       swEn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  scinv_phase_ctrl #(
    .REF_W(REF_W), .PHASE_CLKS(PH), .DEAD_CLKS(DD)
  ) u_scinv_phase_ctrl (
    .clk(clk), .rst(rst), .refSample(refSample), .outMag(outMag), .swEn(swEn)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] xferPattern(input int r, input int om);
    int m;
    logic [7:0] p;
    bit vc;
    m  = (r < 0) ? -r : r;
    vc = (m >= om);
    p  = 8'h00;
    if (3 * m >= 2 * FS)  p = 8'h06 | (vc ? 8'h20 : 8'h00);
    else if (3 * m >= FS) p = 8'h02 | (vc ? 8'h10 : 8'h00);
    else                  p = vc ? 8'h08 : 8'h00;
    p = p | ((r >= 0) ? 8'h40 : 8'h80);
    return p;
  endfunction

  function automatic int gainOf(input int r);
    int m;
    m = (r < 0) ? -r : r;
    if (3 * m >= 2 * FS) return 3;
    if (3 * m >= FS)     return 2;
    return 1;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s swEn actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle model
  int mcnt;
  int mRef;
  int mOm;
  logic [7:0] expSw;
  bit modelOn = 0;

  always @(posedge clk) begin
    if (rst) begin
      mcnt <= 0; mRef <= 0; mOm <= 0; expSw <= 8'h00; modelOn <= 1;
    end else begin
      if (mcnt == 0) begin
        mRef <= int'(refSample);
        mOm  <= int'(outMag);
      end
      if (mcnt < PH)                            expSw <= 8'h01;
      else if (mcnt >= PH + DD && mcnt < 2*PH + DD) expSw <= xferPattern(mRef, mOm);
      else                                      expSw <= 8'h00;
      mcnt <= (mcnt == CYC - 1) ? 0 : mcnt + 1;
    end
  end

  // per-clock compare and period tracking
  int clkCount = 0;
  int lastRise = -1;
  logic prevBit0 = 1'b0;

  always @(negedge clk) begin
    string tag;
    logic [7:0] diff;
    clkCount++;
    if (!rst && modelOn && !done) begin
      diff = swEn ^ expSw;
      if (expSw == 8'h01)            tag = "R3";
      else if (expSw == 8'h00)       tag = "R4";
      else if (|diff[7:6])           tag = "R10";
      else if (diff == 8'h20 || diff == 8'h10 || diff == 8'h08) tag = "R9";
      else if (gainOf(mRef) == 3)    tag = "R6";
      else if (gainOf(mRef) == 2)    tag = "R7";
      else                           tag = "R8";
      chk(swEn, expSw, tag);
      if (swEn[0] && !prevBit0) begin
        if (lastRise >= 0) begin
          checks++;
          if (clkCount - lastRise != CYC) begin
            failures++;
            $display("FAIL R2 period actual=%0d expected=%0d", clkCount - lastRise, CYC);
          end
        end
        lastRise = clkCount;
      end
      prevBit0 = swEn[0];
    end
  end

  task automatic toNextXfer(input int r, input int om, input bit flipLate);
    @(negedge clk);
    refSample = REF_W'(r);
    outMag    = REF_W'(om);
    do @(negedge clk); while (swEn[0]);
    do @(negedge clk); while (!swEn[0]);
    if (flipLate) begin
      refSample = REF_W'(-r);
      outMag    = REF_W'(FS - 1);
    end
    do @(negedge clk); while (!(|swEn[7:1]));
  endtask

  task automatic directed(input int r, input int om, input logic [7:0] exp, input string tag);
    toNextXfer(r, om, 1'b0);
    chk(swEn, exp, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(swEn, 8'h00, "R1");
    rst = 1'b0;
    @(negedge clk);
    chk(swEn, 8'h01, "R1");

    // random stimulus, inputs changing every clock
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      refSample = REF_W'($urandom);
      outMag    = REF_W'($urandom_range(0, FS));
    end
    // random stimulus held for whole cycles
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      refSample = REF_W'($urandom);
      outMag    = REF_W'($urandom_range(0, FS));
      repeat (CYC - 1) @(negedge clk);
    end

    // R5: threshold boundaries, boost enabled
    directed(682, 0, 8'h48, "R5");
    directed(683, 0, 8'h52, "R5");
    directed(1365, 0, 8'h52, "R5");
    directed(1366, 0, 8'h66, "R5");
    directed(-1366, 0, 8'ha6, "R5");
    directed(-2048, 0, 8'ha6, "R5");
    directed(0, 0, 8'h48, "R5");
    // R9: equality fires, one above skips
    directed(1000, 1000, 8'h52, "R9");
    directed(1000, 1001, 8'h42, "R9");
    directed(-300, 301, 8'h80, "R9");
    directed(-1500, 1501, 8'ha6 & ~8'h20, "R9");
    // R10: polarity
    directed(-5, 0, 8'h88, "R10");
    // R11: late change ignored within the cycle
    toNextXfer(1500, 0, 1'b1);
    chk(swEn, 8'h66, "R11");

    repeat (2 * CYC) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule